// File: doc/BRIEF.md
# Bit-serial SIMD element row

A row of identical one-bit processing elements that all obey one shared instruction. Each element keeps a private one-bit-wide memory column, an X register, a Y register and a write-enable flag. On an operate cycle every element reads the bit at the common address. It forms a 3-bit index from X, Y and that memory bit, and uses the index to pick one bit of the 8-bit opcode. The opcode is therefore the truth table of any three-input Boolean function. The chosen result, the result of a neighbour, or the value on a shared wired-AND bus is then written to one destination.

Between operate cycles, a host reads or writes single memory bits through a valid/ready request port. A request is accepted on a rising edge where both host_valid and host_ready are high. The requester must hold the request and its fields stable while host_ready is low. host_ready drops whenever an operate strobe is present, so operate cycles always win. Read data comes back on a separate result strobe that cannot be stalled.

Top module: `simd_pe_row`

## Requirements
- R1: For each element, the ALU result is op_tt[{X, Y, M}], where X is index bit 2, Y is bit 1, and M (the element's memory bit at op_addr) is bit 0.
- R2: op_dst selects exactly one target per operate cycle: 0 for memory at op_addr, 1 for X, 2 for Y, 3 for the write-enable flag. The other three keep their values.
- R3: With op_dst = 0, an element whose write-enable flag is 0 leaves its memory bit unchanged.
- R4: On an operate cycle all elements read and write the same address op_addr, each in its own column.
- R5: op_comm = 1 gives element i the ALU result of element i+1, and the highest element receives EDGE_FILL. op_comm = 2 gives element i the result of element i-1, and element 0 receives EDGE_FILL.
- R6: op_comm = 3 makes every element drive the bus, and every element receives the AND of all ALU results.
- R7: op_comm = 4 lets only elements whose write-enable flag is 1 drive the bus. Every element receives the AND of the driven results, or 1 when no element drives.
- R8: op_comm values 0, 5, 6 and 7 give each element its own ALU result.
- R9: host_ready is the inverse of op_valid. An accepted write (host_we = 1) sets only the addressed bit of column host_pe. An accepted read returns that bit on host_rdata, with host_rvalid high for one cycle, on the edge after acceptance.
- R10: Reset clears X and Y to 0, sets every write-enable flag to 1, and leaves host_rvalid low.
- R11: Without op_valid, X, Y and the write-enable flags hold their values, including during host accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operate strobe |
| op_addr | input | ADDR_W | Shared memory address for the operate cycle |
| op_tt | input | 8 | Truth table for the ALU |
| op_dst | input | 2 | Destination code |
| op_comm | input | 3 | Communication code |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted this edge |
| host_we | input | 1 | 1 for write, 0 for read |
| host_pe | input | PE_IDX_W | Target element |
| host_addr | input | ADDR_W | Target memory address |
| host_wdata | input | 1 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 1 | Read data |

## Verification
The bench builds the row with five elements, eight addresses and EDGE_FILL = 1. An odd element count means the middle element has two real neighbours while the two ends each see the fill value. A fill of 1 differs from the default, so a wrong or missing end input shows up in shift results. Eight addresses leave room for a separate scratch location per test step, so earlier results stay readable. Five elements also leave enough write-enable patterns to cover the all-disabled bus case alongside partial masks.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;
  typedef enum logic [1:0] {
    DST_MEM = 2'd0,
    DST_X   = 2'd1,
    DST_Y   = 2'd2,
    DST_WE  = 2'd3
  } dst_e;

  typedef enum logic [2:0] {
    COM_LOCAL      = 3'd0,
    COM_FROM_RIGHT = 3'd1,
    COM_FROM_LEFT  = 3'd2,
    COM_BUS_ALL    = 3'd3,
    COM_BUS_EN     = 3'd4
  } comm_e;
endpackage

// File: rtl/simd_pe_lut.sv
module simd_pe_lut (
  input  logic [7:0] tt,
  input  logic [2:0] sel,
  output logic       y
);
  assign y = tt[sel];
endmodule

// File: rtl/simd_pe_bus.sv
module simd_pe_bus #(
  parameter int NUM_PE = 8
) (
  input  logic [NUM_PE-1:0] val,
  input  logic [NUM_PE-1:0] drv,
  output logic              bus
);
  // undriven lines float high; any driven 0 pulls the bus low
  assign bus = &(val | ~drv);
endmodule

// File: rtl/simd_pe_cell.sv
module simd_pe_cell #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_tt,
  input  logic [1:0]        op_dst,
  input  logic              res_in,
  output logic              alu_out,
  output logic              x_q,
  output logic              y_q,
  output logic              we_q,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wdata,
  output logic              host_bit
);
  import simd_pe_pkg::*;

  logic mem [DEPTH];
  logic m_bit;

  assign m_bit    = mem[op_addr];
  assign host_bit = mem[host_addr];

  simd_pe_lut u_lut (
    .tt  (op_tt),
    .sel ({x_q, y_q, m_bit}),
    .y   (alu_out)
  );

  always_ff @(posedge clk) begin
    if (op_valid) begin
      if (op_dst == DST_MEM && we_q) mem[op_addr] <= res_in;
    end else if (host_wr) begin
      mem[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= 1'b0;
      y_q  <= 1'b0;
      we_q <= 1'b1;
    end else if (op_valid) begin
      case (op_dst)
        DST_X:   x_q  <= res_in;
        DST_Y:   y_q  <= res_in;
        DST_WE:  we_q <= res_in;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simd_pe_row.sv
module simd_pe_row #(
  parameter int   NUM_PE    = 8,
  parameter int   ADDR_W    = 4,
  parameter logic EDGE_FILL = 1'b0,
  localparam int  PE_IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [ADDR_W-1:0]   op_addr,
  input  logic [7:0]          op_tt,
  input  logic [1:0]          op_dst,
  input  logic [2:0]          op_comm,
  input  logic                host_valid,
  output logic                host_ready,
  input  logic                host_we,
  input  logic [PE_IDX_W-1:0] host_pe,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_wdata,
  output logic                host_rvalid,
  output logic                host_rdata
);
  import simd_pe_pkg::*;

  logic [NUM_PE-1:0] alu_vec, res_vec, x_vec, y_vec, we_vec;
  logic [NUM_PE-1:0] host_bit_vec, from_right, from_left, bus_drv;
  logic              bus_val, host_acc;

  assign host_ready = !op_valid;
  assign host_acc   = host_valid && host_ready;
  assign bus_drv    = (op_comm == COM_BUS_ALL) ? {NUM_PE{1'b1}} : we_vec;

  simd_pe_bus #(.NUM_PE(NUM_PE)) u_bus (
    .val (alu_vec),
    .drv (bus_drv),
    .bus (bus_val)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    if (i == NUM_PE - 1) begin : g_rend
      assign from_right[i] = EDGE_FILL;
    end else begin : g_rmid
      assign from_right[i] = alu_vec[i+1];
    end
    if (i == 0) begin : g_lend
      assign from_left[i] = EDGE_FILL;
    end else begin : g_lmid
      assign from_left[i] = alu_vec[i-1];
    end

    always_comb begin
      case (op_comm)
        COM_FROM_RIGHT: res_vec[i] = from_right[i];
        COM_FROM_LEFT:  res_vec[i] = from_left[i];
        COM_BUS_ALL,
        COM_BUS_EN:     res_vec[i] = bus_val;
        default:        res_vec[i] = alu_vec[i];
      endcase
    end

    simd_pe_cell #(.ADDR_W(ADDR_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_addr    (op_addr),
      .op_tt      (op_tt),
      .op_dst     (op_dst),
      .res_in     (res_vec[i]),
      .alu_out    (alu_vec[i]),
      .x_q        (x_vec[i]),
      .y_q        (y_vec[i]),
      .we_q       (we_vec[i]),
      .host_wr    (host_acc && host_we && (host_pe == PE_IDX_W'(i))),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_bit   (host_bit_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= 1'b0;
    end else begin
      host_rvalid <= host_acc && !host_we;
      if (host_acc && !host_we)
        host_rdata <= (32'(host_pe) < NUM_PE) ? host_bit_vec[host_pe] : 1'b0;
    end
  end
endmodule

// File: rtl/simd_pe_row_chk.sv
module simd_pe_row_chk #(
  parameter int NUM_PE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_dst,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_we,
  input logic              host_rvalid,
  input logic [NUM_PE-1:0] x_vec,
  input logic [NUM_PE-1:0] y_vec,
  input logic [NUM_PE-1:0] we_vec
);
  // R11
  idle_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(x_vec) && $stable(y_vec) && $stable(we_vec)));

  // R2
  x_only_on_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dst != 2'd1) |=> $stable(x_vec));

  // R2
  y_only_on_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dst != 2'd2) |=> $stable(y_vec));

  // R2
  we_only_on_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dst != 2'd3) |=> $stable(we_vec));

  // R9
  read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we) |=> host_rvalid);

  // R9
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_valid || !host_ready || host_we) |=> !host_rvalid);
endmodule

bind simd_pe_row simd_pe_row_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_dst      (op_dst),
  .host_valid  (host_valid),
  .host_ready  (host_ready),
  .host_we     (host_we),
  .host_rvalid (host_rvalid),
  .x_vec       (x_vec),
  .y_vec       (y_vec),
  .we_vec      (we_vec)
);

// File: tb/simd_pe_row_tb_top.sv
module simd_pe_row_tb_top;
  localparam int   NPE   = 5;
  localparam int   AW    = 3;
  localparam int   DEPTH = 1 << AW;
  localparam logic FILL  = 1'b1;
  localparam int   PW    = $clog2(NPE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0] op_tt = '0;
  logic [1:0] op_dst = '0;
  logic [2:0] op_comm = '0;
  logic host_valid = 1'b0, host_we = 1'b0, host_wdata = 1'b0;
  logic [PW-1:0] host_pe = '0;
  logic [AW-1:0] host_addr = '0;
  logic host_ready, host_rvalid, host_rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [NPE-1:0] mem_m [DEPTH];
  logic [NPE-1:0] x_m, y_m, we_m;
  logic  exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  simd_pe_row #(.NUM_PE(NPE), .ADDR_W(AW), .EDGE_FILL(FILL)) dut_i (
    .clk, .rst_n, .op_valid, .op_addr, .op_tt, .op_dst, .op_comm,
    .host_valid, .host_ready, .host_we, .host_pe, .host_addr, .host_wdata,
    .host_rvalid, .host_rdata
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected rvalid", 1, 0);
      else begin
        automatic logic e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(host_rdata === e, t, int'(host_rdata), int'(e));
      end
    end
  end

  task automatic host_write(input int pe, input int a, input logic d);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_pe = PW'(pe); host_addr = AW'(a); host_wdata = d;
    mem_m[a][pe] = d;
    @(negedge clk);
    host_valid = 0; host_we = 0;
  endtask

  task automatic host_read(input int pe, input int a, input string tag);
    @(negedge clk);
    host_valid = 1; host_we = 0; host_pe = PW'(pe); host_addr = AW'(a);
    exp_q.push_back(mem_m[a][pe]);
    tag_q.push_back(tag);
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic read_row(input int a, input string tag);
    for (int i = 0; i < NPE; i++) host_read(i, a, tag);
  endtask

  task automatic model_op(input logic [7:0] tt, input logic [1:0] dst,
                          input logic [2:0] comm, input int a);
    logic [NPE-1:0] alu, res, drv;
    logic bus;
    for (int i = 0; i < NPE; i++) alu[i] = tt[{x_m[i], y_m[i], mem_m[a][i]}];
    drv = (comm == 3'd3) ? '1 : we_m;
    bus = &(alu | ~drv);
    for (int i = 0; i < NPE; i++) begin
      case (comm)
        3'd1: res[i] = (i == NPE-1) ? FILL : alu[(i+1) % NPE];
        3'd2: res[i] = (i == 0) ? FILL : alu[(i+NPE-1) % NPE];
        3'd3, 3'd4: res[i] = bus;
        default: res[i] = alu[i];
      endcase
    end
    case (dst)
      2'd0: mem_m[a] = (mem_m[a] & ~we_m) | (res & we_m);
      2'd1: x_m = res;
      2'd2: y_m = res;
      default: we_m = res;
    endcase
  endtask

  task automatic do_op(input logic [7:0] tt, input logic [1:0] dst,
                       input logic [2:0] comm, input int a);
    @(negedge clk);
    op_valid = 1; op_tt = tt; op_dst = dst; op_comm = comm; op_addr = AW'(a);
    model_op(tt, dst, comm, a);
    @(negedge clk);
    op_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    x_m = '0; y_m = '0; we_m = '1;
    for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 / R9 idle port state after reset
    check(host_rvalid == 1'b0, "R10 rvalid after reset", int'(host_rvalid), 0);
    check(host_ready == 1'b1, "R9 ready when idle", int'(host_ready), 1);

    // R9: clear all memory, then load patterns
    for (int a = 0; a < DEPTH; a++)
      for (int i = 0; i < NPE; i++) host_write(i, a, 1'b0);
    for (int i = 0; i < NPE; i++) host_write(i, 0, logic'((5'b01101 >> i) & 1));
    for (int i = 0; i < NPE; i++) host_write(i, 1, logic'((5'b00110 >> i) & 1));
    read_row(0, "R9 host write/read addr0");
    read_row(1, "R9 host write/read addr1");

    // R10: X resets to 0, WE to 1 (write of X=0 must land where 1s were)
    for (int i = 0; i < NPE; i++) host_write(i, 2, 1'b1);
    do_op(8'hF0, 2'd0, 3'd0, 2);
    read_row(2, "R10 X reset value");
    do_op(8'hCC, 2'd0, 3'd0, 7);
    read_row(7, "R10 Y reset value");

    // R1 / R2 / R4: load X and Y, then three-input functions
    do_op(8'hAA, 2'd1, 3'd0, 0);
    do_op(8'hAA, 2'd2, 3'd0, 1);
    read_row(0, "R2 dst X leaves memory");
    do_op(8'h96, 2'd0, 3'd0, 3);
    read_row(3, "R1 xor3");
    do_op(8'hE8, 2'd0, 3'd6, 4);
    read_row(4, "R8 majority with comm 6");

    // R3: write enable from addr0 pattern gates memory writes
    do_op(8'hAA, 2'd3, 3'd0, 0);
    do_op(8'hFF, 2'd0, 3'd0, 5);
    read_row(5, "R3 conditional write");

    // R7: bus driven only by enabled elements, result into X
    do_op(8'hAA, 2'd1, 3'd4, 1);
    do_op(8'hFF, 2'd3, 3'd0, 0);
    do_op(8'hF0, 2'd0, 3'd0, 6);
    read_row(6, "R7 gated bus partial");
    // R7: nobody drives -> 1
    do_op(8'h00, 2'd3, 3'd0, 0);
    do_op(8'h00, 2'd2, 3'd4, 0);
    do_op(8'hFF, 2'd3, 3'd0, 0);
    do_op(8'hCC, 2'd0, 3'd0, 6);
    read_row(6, "R7 gated bus none driving");

    // R5: shifts through the memory bit at the same address
    do_op(8'hAA, 2'd0, 3'd1, 0);
    read_row(0, "R5 from right with fill");
    do_op(8'hAA, 2'd0, 3'd2, 1);
    read_row(1, "R5 from left with fill");

    // R6: all drive
    do_op(8'hAA, 2'd0, 3'd3, 0);
    read_row(0, "R6 bus all");
    do_op(8'hFF, 2'd0, 3'd3, 7);
    read_row(7, "R6 bus all ones");

    // R9 / R11: host write collides with operate cycle
    @(negedge clk);
    op_valid = 1; op_tt = 8'hF0; op_dst = 2'd1; op_comm = 3'd0; op_addr = '0;
    host_valid = 1; host_we = 1; host_pe = PW'(2); host_addr = AW'(4); host_wdata = ~mem_m[4][2];
    model_op(8'hF0, 2'd1, 3'd0, 0);
    #1;
    check(host_ready == 1'b0, "R9 ready low during operate", int'(host_ready), 0);
    @(negedge clk);
    op_valid = 0;
    #1;
    check(host_ready == 1'b1, "R9 ready back", int'(host_ready), 1);
    mem_m[4][2] = host_wdata;
    @(negedge clk);
    host_valid = 0; host_we = 0;
    read_row(4, "R9 held write lands after operate");
    do_op(8'hF0, 2'd0, 3'd0, 5);
    read_row(5, "R11 X kept through host traffic");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule